// File: doc/BRIEF.md
# Dual Instruction Fetch Buffer Controller

This block sits between an instruction fetch stage and an instruction cache and manages two line-sized fetch buffers that work as a ping-pong pair. For each fetch it rounds the program counter down to a fetch line of 8 or 16 bytes, chosen per fetch. A buffer whose tag already holds that line becomes the current buffer. If neither buffer holds it, a fixed default buffer is taken. The other buffer is always made to hold the next sequential line.

A buffer that must change its line is retagged. The controller then issues a cache load for it, tagged with a fresh request number from a wrapping counter. The demand load for the current buffer and the prefetch load for the other buffer leave on two separate request channels in the same cycle. The cache returns a completion carrying a request number, and only the buffer waiting on that exact number is released.

When cycle counting is on, the fetch is held until the current buffer has no outstanding load. The number of wait cycles is reported with the done pulse. A pending branch penalty, loaded by a separate strobe, is spent as extra stall cycles. It is spent only on the first instruction of a packet, and only once. When cycle counting is off, the loads are still issued but the fetch completes at once. When both the cache and cycle counting are off, the block does nothing except acknowledge the fetch.

Top module: `fetch_pingpong_ctrl`

## Requirements
- R1: The fetch line address is `fetch_pc` with its low 3 bits cleared when `wide_fetch`=0 (8-byte line), or its low 4 bits cleared when `wide_fetch`=1 (16-byte line). Every request address is such a line address.
- R2: Buffer 0 becomes current if its tag equals the line address; otherwise buffer 1 does if its tag matches; otherwise the default buffer (parameter `DEFAULT_BUF`, 0 by default) does. `fetch_buf` reports the current buffer together with `fetch_done`.
- R3: If the current buffer's tag differs from the line address, it is retagged and a demand load is issued: `dmd_valid`=1 for one cycle, starting the cycle after the accept, with `dmd_addr` = line and `dmd_buf` = current buffer.
- R4: The other buffer (index = current XOR 1) must hold line + line size. If it does not, it is retagged and a prefetch is issued in the same cycle as any demand load, with `pf_addr` = line + line size and `pf_buf` = other buffer.
- R5: Request numbers come from a counter that resets to `REQ_INIT` and wraps modulo 2^REQ_W. A demand load takes the counter value. A prefetch takes the next value after any demand issued with it. The counter advances by the number of loads issued.
- R6: A completion (`cmpl_valid`, `cmpl_id`) clears a buffer's outstanding state only when `cmpl_id` equals the number that buffer's load was issued with; other numbers are ignored.
- R7: With counting on, the fetch stalls until the current buffer has no outstanding load. Let P be the penalty spent and L the cycle (counted from the accept) in which the completion for the current buffer is driven. Then `fetch_wait` = L-P+1 if that buffer was outstanding and L>=P, else 0, and `fetch_done` pulses 1+P+`fetch_wait` cycles after the cycle of the accept edge.
- R8: The pending penalty loaded by `pen_set`/`pen_cycles` is spent only when counting is on and `first_of_packet`=1. It is spent at most once and then cleared; otherwise it stays pending.
- R9: With `ic_enable`=0 and `cyc_count_en`=0, a fetch issues no load, changes no buffer, request counter or penalty, and completes in the cycle after the accept with `fetch_wait`=0.
- R10: With `cyc_count_en`=0 and `ic_enable`=1, loads are issued as in R3 to R5, and the fetch completes in the cycle after the accept with `fetch_wait`=0.
- R11: After reset all outputs are 0 and both buffers are invalid, so the first fetch issues both a demand load and a prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ic_enable | input | 1 | Instruction cache enabled |
| cyc_count_en | input | 1 | Cycle counting enabled (stall accounting) |
| wide_fetch | input | 1 | 0: 8-byte line, 1: 16-byte line |
| fetch_valid | input | 1 | Fetch request, taken when the block is idle |
| fetch_pc | input | ADDR_W | Fetch program counter |
| first_of_packet | input | 1 | Fetch is the first instruction of a packet |
| pen_set | input | 1 | Load a pending branch penalty |
| pen_cycles | input | PEN_W | Penalty in cycles |
| cmpl_valid | input | 1 | Cache load completion strobe |
| cmpl_id | input | REQ_W | Request number being completed |
| dmd_valid | output | 1 | Demand load request |
| dmd_addr | output | ADDR_W | Demand line address |
| dmd_buf | output | 1 | Buffer receiving the demand line |
| dmd_id | output | REQ_W | Demand request number |
| pf_valid | output | 1 | Prefetch load request |
| pf_addr | output | ADDR_W | Prefetch line address |
| pf_buf | output | 1 | Buffer receiving the prefetch line |
| pf_id | output | REQ_W | Prefetch request number |
| fetch_done | output | 1 | One-cycle pulse: fetch finished |
| fetch_wait | output | WAIT_W | Wait cycles spent on the current buffer |
| fetch_buf | output | 1 | Buffer that served the fetch |

## Verification
The bench builds the block with `REQ_INIT` set three below the wrap point. The request counter therefore rolls over to zero within the first few loads, and R5's modulo behaviour is checked early instead of needing billions of requests. `DEFAULT_BUF`, `ADDR_W`, `PEN_W` and `WAIT_W` keep their defaults. A small pool of program counters, with occasional switches of line size, makes hits in both buffers, misses in both, and hits on a buffer whose prefetch is still outstanding all common. Completion latencies and penalties up to five cycles cover both orderings of penalty against completion in R7.

// File: rtl/fetch_pp_pkg.sv
package fetch_pp_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_PEN  = 2'd1,
        FS_CHK  = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/fetch_line_slot.sv
module fetch_line_slot #(
    parameter int ADDR_W = 32,
    parameter int REQ_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_tag,
    input  logic [REQ_W-1:0]  ld_id,
    input  logic              cmpl_valid,
    input  logic [REQ_W-1:0]  cmpl_id,
    output logic              valid,
    output logic [ADDR_W-1:0] tag,
    output logic              pend
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] tag;
        logic              pend;
        logic [REQ_W-1:0]  id;
    } slot_t;

    slot_t s_d, s_q;
    logic  hit_cmpl;

    always_comb begin
        s_d      = s_q;
        hit_cmpl = s_q.pend && cmpl_valid && (cmpl_id == s_q.id);
        if (hit_cmpl) begin
            s_d.pend = 1'b0;
        end
        if (ld) begin
            s_d.valid = 1'b1;
            s_d.tag   = ld_tag;
            s_d.pend  = 1'b1;
            s_d.id    = ld_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.valid;
    assign tag   = s_q.tag;
    assign pend  = s_q.pend;

    // R6: a matching completion releases the slot
    p_match_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cmpl_valid && cmpl_id == s_q.id && !ld) |=> !pend);

    // R6: a non-matching completion leaves it outstanding
    p_other_id_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(cmpl_valid && cmpl_id == s_q.id)) |=> pend);

    // R11: an outstanding load implies a valid tag
    p_pend_has_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> valid);

endmodule

// File: rtl/fetch_pingpong_ctrl.sv
module fetch_pingpong_ctrl #(
    parameter int          ADDR_W      = 32,
    parameter int          REQ_W       = 32,
    parameter int          PEN_W       = 4,
    parameter int          WAIT_W      = 8,
    parameter logic [31:0] REQ_INIT    = 32'h8000_0000,
    parameter bit          DEFAULT_BUF = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ic_enable,
    input  logic              cyc_count_en,
    input  logic              wide_fetch,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              first_of_packet,
    input  logic              pen_set,
    input  logic [PEN_W-1:0]  pen_cycles,
    input  logic              cmpl_valid,
    input  logic [REQ_W-1:0]  cmpl_id,
    output logic              dmd_valid,
    output logic [ADDR_W-1:0] dmd_addr,
    output logic              dmd_buf,
    output logic [REQ_W-1:0]  dmd_id,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              pf_buf,
    output logic [REQ_W-1:0]  pf_id,
    output logic              fetch_done,
    output logic [WAIT_W-1:0] fetch_wait,
    output logic              fetch_buf
);
    import fetch_pp_pkg::*;

    localparam int          NBUF     = 2;
    localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(16);
    localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

    typedef struct packed {
        fetch_state_e      state;
        logic [PEN_W-1:0]  pen;
        logic [PEN_W-1:0]  cnt;
        logic              cur;
        logic [WAIT_W-1:0] waitc;
        logic [REQ_W-1:0]  rq;
        logic              dmd_v;
        logic [ADDR_W-1:0] dmd_a;
        logic              dmd_b;
        logic [REQ_W-1:0]  dmd_id;
        logic              pf_v;
        logic [ADDR_W-1:0] pf_a;
        logic              pf_b;
        logic [REQ_W-1:0]  pf_id;
        logic              done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [NBUF-1:0]   slot_valid;
    logic [NBUF-1:0]   slot_pend;
    logic [ADDR_W-1:0] slot_tag [NBUF];
    logic [NBUF-1:0]   slot_ld;
    logic [REQ_W-1:0]  slot_ld_id [NBUF];
    logic [ADDR_W-1:0] slot_ld_tag [NBUF];

    logic              active;
    logic              accept;
    logic              issue;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] line;
    logic [ADDR_W-1:0] next_line;
    logic [NBUF-1:0]   hit;
    logic              cur;
    logic              oth;
    logic              need_dmd;
    logic              need_pf;
    logic [REQ_W-1:0]  id_dmd;
    logic [REQ_W-1:0]  id_pf;

    // line selection and buffer choice
    always_comb begin
        active    = ic_enable | cyc_count_en;
        accept    = (r_q.state == FS_IDLE) && fetch_valid;
        issue     = accept && active;
        step      = wide_fetch ? STEP_W : STEP_N;
        line      = fetch_pc & ~(step - ADDR_W'(1));
        next_line = line + step;
        for (int i = 0; i < NBUF; i++) begin
            hit[i] = slot_valid[i] && (slot_tag[i] == line);
        end
        if (hit[0])      cur = 1'b0;
        else if (hit[1]) cur = 1'b1;
        else             cur = DEFAULT_BUF;
        oth      = ~cur;
        need_dmd = !hit[cur];
        need_pf  = !(slot_valid[oth] && (slot_tag[oth] == next_line));
        id_dmd   = r_q.rq;
        id_pf    = r_q.rq + REQ_W'(need_dmd);
    end

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_slot
            always_comb begin
                if (cur == 1'(g)) begin
                    slot_ld[g]     = issue && need_dmd;
                    slot_ld_tag[g] = line;
                    slot_ld_id[g]  = id_dmd;
                end else begin
                    slot_ld[g]     = issue && need_pf;
                    slot_ld_tag[g] = next_line;
                    slot_ld_id[g]  = id_pf;
                end
            end

            fetch_line_slot #(
                .ADDR_W (ADDR_W),
                .REQ_W  (REQ_W)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .ld         (slot_ld[g]),
                .ld_tag     (slot_ld_tag[g]),
                .ld_id      (slot_ld_id[g]),
                .cmpl_valid (cmpl_valid),
                .cmpl_id    (cmpl_id),
                .valid      (slot_valid[g]),
                .tag        (slot_tag[g]),
                .pend       (slot_pend[g])
            );
        end
    endgenerate

    // next-state
    always_comb begin
        r_d       = r_q;
        r_d.dmd_v = 1'b0;
        r_d.pf_v  = 1'b0;
        r_d.done  = 1'b0;

        case (r_q.state)
            FS_IDLE: begin
                if (accept) begin
                    r_d.cur   = cur;
                    r_d.waitc = '0;
                    if (issue) begin
                        r_d.dmd_v  = need_dmd;
                        r_d.dmd_a  = line;
                        r_d.dmd_b  = cur;
                        r_d.dmd_id = id_dmd;
                        r_d.pf_v   = need_pf;
                        r_d.pf_a   = next_line;
                        r_d.pf_b   = oth;
                        r_d.pf_id  = id_pf;
                        r_d.rq     = r_q.rq + REQ_W'(need_dmd) + REQ_W'(need_pf);
                    end
                    if (!cyc_count_en) begin
                        r_d.done = 1'b1;
                    end else if (first_of_packet && (r_q.pen != '0)) begin
                        r_d.cnt   = r_q.pen;
                        r_d.pen   = '0;
                        r_d.state = FS_PEN;
                    end else begin
                        r_d.state = FS_CHK;
                    end
                end
            end
            FS_PEN: begin
                if (r_q.cnt <= PEN_W'(1)) r_d.state = FS_CHK;
                else                      r_d.cnt   = r_q.cnt - PEN_W'(1);
            end
            FS_CHK: begin
                if (!slot_pend[r_q.cur]) begin
                    r_d.done  = 1'b1;
                    r_d.state = FS_IDLE;
                end else if (r_q.waitc != WAIT_MAX) begin
                    r_d.waitc = r_q.waitc + WAIT_W'(1);
                end
            end
            default: r_d.state = FS_IDLE;
        endcase

        if (pen_set) begin
            r_d.pen = pen_cycles;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= FS_IDLE;
            r_q.rq    <= REQ_W'(REQ_INIT);
        end else begin
            r_q <= r_d;
        end
    end

    assign dmd_valid  = r_q.dmd_v;
    assign dmd_addr   = r_q.dmd_a;
    assign dmd_buf    = r_q.dmd_b;
    assign dmd_id     = r_q.dmd_id;
    assign pf_valid   = r_q.pf_v;
    assign pf_addr    = r_q.pf_a;
    assign pf_buf     = r_q.pf_b;
    assign pf_id      = r_q.pf_id;
    assign fetch_done = r_q.done;
    assign fetch_wait = r_q.waitc;
    assign fetch_buf  = r_q.cur;

    // R1: request addresses are line aligned
    p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_valid |-> dmd_addr[2:0] == 3'b000) and (pf_valid |-> pf_addr[2:0] == 3'b000));

    // R3: demand and prefetch never target the same buffer
    p_bufs_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_valid && pf_valid) |-> (dmd_buf != pf_buf));

    // R4: the prefetch line follows the current buffer's line by one line
    p_pf_next_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ((pf_addr - slot_tag[fetch_buf]) == STEP_N ||
                      (pf_addr - slot_tag[fetch_buf]) == STEP_W));

    // R5: paired requests take consecutive numbers
    p_id_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_valid && pf_valid) |-> (pf_id == dmd_id + REQ_W'(1)));

    // R9: an idle-mode fetch issues nothing and completes next cycle
    p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !active) |=> (!dmd_valid && !pf_valid && fetch_done && fetch_wait == '0));

    // R10: without counting the fetch completes next cycle
    p_nocount_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cyc_count_en) |=> (fetch_done && fetch_wait == '0));

endmodule

// File: tb/tb_fetch_pingpong_ctrl.sv
module tb_fetch_pingpong_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam int          RW         = 32;
    localparam int          PW         = 4;
    localparam int          WW         = 8;
    localparam logic [31:0] RQ_START   = 32'hFFFF_FFFD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ic_enable = 1'b1;
    logic          cyc_count_en = 1'b1;
    logic          wide_fetch = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          first_of_packet = 1'b0;
    logic          pen_set = 1'b0;
    logic [PW-1:0] pen_cycles = '0;
    logic          cmpl_valid = 1'b0;
    logic [RW-1:0] cmpl_id = '0;
    logic          dmd_valid, dmd_buf, pf_valid, pf_buf, fetch_done, fetch_buf;
    logic [AW-1:0] dmd_addr, pf_addr;
    logic [RW-1:0] dmd_id, pf_id;
    logic [WW-1:0] fetch_wait;

    fetch_pingpong_ctrl #(
        .ADDR_W (AW), .REQ_W (RW), .PEN_W (PW), .WAIT_W (WW),
        .REQ_INIT (RQ_START), .DEFAULT_BUF (1'b0)
    ) dut (
        .clk (clk), .rst_n (rst_n), .ic_enable (ic_enable),
        .cyc_count_en (cyc_count_en), .wide_fetch (wide_fetch),
        .fetch_valid (fetch_valid), .fetch_pc (fetch_pc),
        .first_of_packet (first_of_packet), .pen_set (pen_set),
        .pen_cycles (pen_cycles), .cmpl_valid (cmpl_valid), .cmpl_id (cmpl_id),
        .dmd_valid (dmd_valid), .dmd_addr (dmd_addr), .dmd_buf (dmd_buf),
        .dmd_id (dmd_id), .pf_valid (pf_valid), .pf_addr (pf_addr),
        .pf_buf (pf_buf), .pf_id (pf_id), .fetch_done (fetch_done),
        .fetch_wait (fetch_wait), .fetch_buf (fetch_buf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // reference model state
    bit        m_v    [2];
    bit [31:0] m_tag  [2];
    bit        m_pend [2];
    bit [31:0] m_id   [2];
    bit [31:0] m_rq;
    int        m_pen;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] line_of(input bit [31:0] pc, input bit wide);
        return wide ? (pc & ~32'hF) : (pc & ~32'h7);
    endfunction

    task automatic set_pen(input int v);
        pen_set    = 1'b1;
        pen_cycles = PW'(v);
        @(posedge clk); @(negedge clk);
        pen_set = 1'b0;
        m_pen   = v;
    endtask

    task automatic do_fetch(input bit [31:0] pc, input bit wide, input bit first,
                            input bit ic, input bit cyc, input int lat,
                            input bit keep_other);
        bit [31:0] step, ln, nl, cid, oid, e_did, e_pid;
        bit        h0, h1, cur, oth, nd, np, act, cp, op;
        int        pen_used, w, exp_c, last;
        bit        seen_early;

        step = wide ? 32'd16 : 32'd8;
        ln   = line_of(pc, wide);                       // R1
        nl   = ln + step;
        h0   = m_v[0] && m_tag[0] == ln;
        h1   = m_v[1] && m_tag[1] == ln;
        cur  = h0 ? 1'b0 : (h1 ? 1'b1 : 1'b0);          // R2
        oth  = ~cur;
        nd   = !(m_v[cur] && m_tag[cur] == ln);
        np   = !(m_v[oth] && m_tag[oth] == nl);
        act  = ic || cyc;
        e_did = m_rq;
        e_pid = m_rq + (nd ? 32'd1 : 32'd0);
        if (act) begin
            if (nd) begin m_v[cur] = 1; m_tag[cur] = ln; m_pend[cur] = 1; m_id[cur] = e_did; end
            if (np) begin m_v[oth] = 1; m_tag[oth] = nl; m_pend[oth] = 1; m_id[oth] = e_pid; end
            m_rq = m_rq + (nd ? 32'd1 : 32'd0) + (np ? 32'd1 : 32'd0);
        end
        pen_used = 0;
        if (cyc && first && m_pen > 0) begin pen_used = m_pen; m_pen = 0; end   // R8

        ic_enable = ic; cyc_count_en = cyc; wide_fetch = wide;
        fetch_pc = pc; first_of_packet = first; fetch_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;

        // request channels, one cycle after the accept
        chk(dmd_valid == (act && nd), act ? "R3" : "R9", "dmd_valid", 32'(dmd_valid), 32'(act && nd));
        if (act && nd) begin
            chk(dmd_addr == ln, "R1", "dmd_addr", dmd_addr, ln);
            chk(dmd_buf == cur, "R2", "dmd_buf", 32'(dmd_buf), 32'(cur));
            chk(dmd_id == e_did, "R5", "dmd_id", dmd_id, e_did);
        end
        chk(pf_valid == (act && np), act ? "R4" : "R9", "pf_valid", 32'(pf_valid), 32'(act && np));
        if (act && np) begin
            chk(pf_addr == nl, "R4", "pf_addr", pf_addr, nl);
            chk(pf_buf == oth, "R4", "pf_buf", 32'(pf_buf), 32'(oth));
            chk(pf_id == e_pid, "R5", "pf_id", pf_id, e_pid);
        end

        cp  = m_pend[cur]; cid = m_id[cur];
        op  = m_pend[oth]; oid = m_id[oth];
        w   = 0;
        if (!cyc) exp_c = 0;                           // R9, R10
        else begin
            if (cp && lat >= pen_used) w = lat - pen_used + 1;
            exp_c = 1 + pen_used + w;                   // R7, R8
        end
        last = (exp_c > lat + 1) ? exp_c : lat + 1;
        seen_early = 1'b0;
        for (int c = 0; c <= last; c++) begin
            if (c == exp_c) begin
                chk(fetch_done == 1'b1, cyc ? "R7" : (act ? "R10" : "R9"),
                    "fetch_done timing", 32'(fetch_done), 32'd1);
                chk(fetch_wait == WW'(w), "R7", "fetch_wait", 32'(fetch_wait), 32'(w));
                chk(fetch_buf == cur, "R2", "fetch_buf", 32'(fetch_buf), 32'(cur));
            end else if (fetch_done) begin
                seen_early = 1'b1;
            end
            if (cp && c == lat) begin
                cmpl_valid = 1'b1; cmpl_id = cid; m_pend[cur] = 0;
            end else if (op && !keep_other && c == lat + 1) begin
                cmpl_valid = 1'b1; cmpl_id = oid; m_pend[oth] = 0;
            end else if (c < lat) begin
                cmpl_valid = 1'b1; cmpl_id = cid + 32'h4000_0000;   // R6: foreign number
            end else begin
                cmpl_valid = 1'b0;
            end
            @(posedge clk); @(negedge clk);
        end
        cmpl_valid = 1'b0;
        chk(!seen_early, "R7", "no stray fetch_done", 32'(seen_early), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        bit        wide;
        bit [31:0] pc;
        void'($urandom(32'd4711));
        for (int i = 0; i < 2; i++) begin m_v[i] = 0; m_tag[i] = 0; m_pend[i] = 0; m_id[i] = 0; end
        m_rq = RQ_START; m_pen = 0;

        repeat (3) @(negedge clk);
        // R11: reset values
        chk(!dmd_valid && !pf_valid && !fetch_done && fetch_wait == 0,
            "R11", "outputs in reset", {dmd_valid, pf_valid, fetch_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dmd_valid && !pf_valid && !fetch_done, "R11", "outputs after reset",
            {dmd_valid, pf_valid, fetch_done}, 32'd0);

        // R11 first fetch misses both; R5 numbering from REQ_INIT
        do_fetch(32'h1004, 0, 0, 1, 1, 2, 0);
        // R2 hit in buffer 1, prefetch wraps the counter (R5)
        do_fetch(32'h100C, 0, 0, 1, 1, 0, 0);
        do_fetch(32'h1013, 0, 0, 1, 1, 1, 0);
        // R1 16-byte lines
        do_fetch(32'h1017, 1, 0, 1, 1, 1, 0);
        do_fetch(32'h200F, 1, 0, 1, 1, 3, 0);
        // R8 penalty held when not first, then spent once
        set_pen(3);
        do_fetch(32'h2010, 1, 0, 1, 1, 0, 0);
        do_fetch(32'h4000, 1, 1, 1, 1, 1, 0);
        do_fetch(32'h4000, 1, 1, 1, 1, 0, 0);
        // R7 completion later than the penalty
        set_pen(2);
        do_fetch(32'h5000, 0, 1, 1, 1, 5, 0);
        // R7 hit on a buffer whose prefetch is still outstanding
        do_fetch(32'h6000, 0, 0, 1, 1, 0, 1);
        do_fetch(32'h6008, 0, 0, 1, 1, 2, 0);
        // R10 counting off: loads go out, no stall, penalty kept
        set_pen(4);
        do_fetch(32'h7000, 0, 1, 1, 0, 2, 0);
        // R9 both off: nothing changes, then a hit proves buffers kept
        do_fetch(32'h9000, 0, 1, 0, 0, 1, 0);
        do_fetch(32'h7000, 0, 0, 1, 1, 0, 0);
        do_fetch(32'h7004, 0, 1, 1, 1, 1, 0);

        // constrained random mix
        wide = 0;
        for (int n = 0; n < 400; n++) begin
            bit ic_r, cy_r;
            if ($urandom_range(0, 5) == 0) wide = ~wide;
            pc = 32'h3000 + 32'($urandom_range(0, 11)) * 8 + 32'($urandom_range(0, 7));
            if ($urandom_range(0, 4) == 0) set_pen($urandom_range(1, 4));
            ic_r = 1; cy_r = 1;
            case ($urandom_range(0, 9))
                0: cy_r = 0;
                1: begin ic_r = 0; cy_r = 0; end
                2: ic_r = 0;
                default: ;
            endcase
            do_fetch(pc, wide, 1'($urandom_range(0, 2) == 0), ic_r, cy_r,
                     $urandom_range(0, 4), 1'($urandom_range(0, 3) == 0));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule